// File: doc/BRIEF.md
# Multichannel DAC Double-Buffered Register Bank

This block sits on an 8-bit host I/O bus and feeds 16-bit codes to a bank of DAC channels. Every channel owns two byte addresses: the even one holds the low byte of its code and the odd one holds the high byte. Bytes land first in per-channel input registers. The assembled 16-bit value then moves to a per-channel output latch, which drives that converter's data lines.

A static mode input selects one of two ways to move data into the latches. In individual mode, a write to a channel's high-byte address loads that channel's latch at once. In simultaneous mode, writes only fill the input registers. A read of any address in the block then copies all input registers into all latches on the same clock edge, so several axes change together. A second static strap selects the reset code of every register: code 0 for unipolar zero or mid-scale for bipolar zero. The block base address comes from switch inputs and is aligned to the size of the block.

Top module: `dac_bank`

## Requirements
- R1: While rst_ni is low, every output latch is 0x0000 when bip_zero_i is 0 and 0x8000 when it is 1. The low input register resets to 0x00. The high input register resets to the top byte of that same code.
- R2: A write to a channel's low-byte address (address bit 0 = 0) updates only that channel's low input register. No output latch changes.
- R3: With simul_mode_i = 0, a write to a channel's high-byte address (bit 0 = 1) loads that channel's latch with {written byte, stored low byte}. Bit 7 of the high byte is the code MSB, and the latch is visible after the accepting clock edge. Other channels keep their values.
- R4: With simul_mode_i = 1, no write changes any output latch.
- R5: With simul_mode_i = 1, an accepted read of any in-range address copies each channel's {high, low} input registers into its latch on one edge.
- R6: An access is in range only when io_cycle_i is 1 and addr_i[ADDR_W-1:5] equals base_sw_i. The channel number is taken from addr_i[4:1]. Out-of-range writes and reads have no effect.
- R7: A transfer fires once per read strobe, on its first high cycle. Holding rd_i high does not repeat it, and writes made while rd_i stays high are not transferred.
- R8: If a write and a read are first seen in the same cycle, the write is accepted in that cycle. The transfer follows one cycle later and includes the written byte.
- R9: Changing simul_mode_i or bip_zero_i outside reset never changes the output latches by itself.
- R10: rdata_o is 0x00 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_sw_i | input | ADDR_W-5 | Base address switches (upper address bits) |
| io_cycle_i | input | 1 | Current bus cycle is an I/O cycle |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | Write strobe, active high |
| rd_i | input | 1 | Read strobe, active high |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data, always 0x00 |
| simul_mode_i | input | 1 | 1 = simultaneous transfer on read, 0 = per-channel update |
| bip_zero_i | input | 1 | Reset code select: 1 = 0x8000, 0 = 0x0000 |
| dac_code_o | output | NUM_CH*16 | Output latches, channel n in bits [16n+15:16n] |

## Verification
Two events can fall in one cycle: a write accepted into an input register and a read-triggered transfer. The bench raises both strobes on the same falling edge, aimed at the high-byte address of one channel. It then checks that after the first rising edge the latches still hold the old value. After the second edge the latch must carry the newly written byte. A separate case holds the read strobe high across a full write. It confirms that nothing moves until a fresh read edge arrives.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int unsigned CODE_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic code_t zero_code(input logic bip);
    return bip ? code_t'(1) << (CODE_W - 1) : '0;
  endfunction
endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned BLK_AW = $clog2(2 * NUM_CH),
  localparam int unsigned CH_W   = BLK_AW - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-BLK_AW-1:0] base_sw_i,
  input  logic                     io_cycle_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  output logic                     wr_fire_o,
  output logic                     rd_fire_o,
  output logic [CH_W-1:0]          ch_sel_o,
  output logic                     hi_sel_o
);
  logic hit, wr_q, rd_q, rd_pend_q, rd_take;

  assign hit      = io_cycle_i && (addr_i[ADDR_W-1:BLK_AW] == base_sw_i);
  assign ch_sel_o = addr_i[BLK_AW-1:1];
  assign hi_sel_o = addr_i[0];

  assign wr_fire_o = wr_i && !wr_q && hit;
  assign rd_take   = (rd_i && !rd_q && hit) || rd_pend_q;
  // a colliding read waits one cycle so it sees the finished write
  assign rd_fire_o = rd_take && !wr_fire_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      wr_q      <= wr_i;
      rd_q      <= rd_i;
      rd_pend_q <= rd_take && wr_fire_o;
    end
  end

  AST_RD_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fire_o |=> !rd_fire_o); // R7
  AST_COLLIDE_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire_o && rd_i && !rd_q && hit) |=> rd_fire_o); // R8
  AST_HELD_RD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_i) && rd_i && !$past(rd_fire_o && 1'b0) && !rd_pend_q) |-> !rd_fire_o); // R7
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_bank_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bip_zero_i,
  input  logic  simul_i,
  input  logic  ld_lo_i,
  input  logic  ld_hi_i,
  input  logic  xfer_i,
  input  byte_t wdata_i,
  output code_t code_o
);
  code_t rst_code;
  byte_t lo_q, hi_q;
  code_t latch_q;

  assign rst_code = zero_code(bip_zero_i);
  assign code_o   = latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= rst_code[BYTE_W-1:0];
      hi_q    <= rst_code[CODE_W-1:BYTE_W];
      latch_q <= rst_code;
    end else begin
      if (ld_lo_i) lo_q <= wdata_i;
      if (ld_hi_i) hi_q <= wdata_i;
      if (xfer_i)                  latch_q <= {hi_q, lo_q};
      else if (ld_hi_i && !simul_i) latch_q <= {wdata_i, lo_q};
    end
  end

  AST_LO_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo_i && !xfer_i) |=> $stable(code_o)); // R2
  AST_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_hi_i && !simul_i && !xfer_i) |=> code_o == {$past(wdata_i), $past(lo_q)}); // R3
  AST_SIMUL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (simul_i && !xfer_i) |=> $stable(code_o)); // R4
  AST_XFER_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> code_o == {$past(hi_q), $past(lo_q)}); // R5
endmodule

// File: rtl/dac_bank.sv
module dac_bank
  import dac_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned BLK_AW = $clog2(2 * NUM_CH),
  localparam int unsigned CH_W   = BLK_AW - 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-BLK_AW-1:0]   base_sw_i,
  input  logic                       io_cycle_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  output logic [BYTE_W-1:0]          rdata_o,
  input  logic                       simul_mode_i,
  input  logic                       bip_zero_i,
  output logic [NUM_CH*CODE_W-1:0]   dac_code_o
);
  logic            wr_fire, rd_fire, hi_sel, xfer;
  logic [CH_W-1:0] ch_sel;

  assign rdata_o = '0;
  assign xfer    = rd_fire && simul_mode_i;

  dac_bus_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_sw_i  (base_sw_i),
    .io_cycle_i (io_cycle_i),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wr_fire_o  (wr_fire),
    .rd_fire_o  (rd_fire),
    .ch_sel_o   (ch_sel),
    .hi_sel_o   (hi_sel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = wr_fire && (ch_sel == CH_W'(g));

    dac_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bip_zero_i (bip_zero_i),
      .simul_i    (simul_mode_i),
      .ld_lo_i    (sel && !hi_sel),
      .ld_hi_i    (sel && hi_sel),
      .xfer_i     (xfer),
      .wdata_i    (wdata_i),
      .code_o     (dac_code_o[g*CODE_W +: CODE_W])
    );
  end

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_fire && !rd_fire) |=> $stable(dac_code_o)); // R9
  AST_FOREIGN_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_cycle_i && !rd_fire) |=> $stable(dac_code_o)); // R6
endmodule

// File: tb/tb_dac_bank.sv
module tb_dac_bank;
  localparam int unsigned CLK_P  = 10;
  localparam int unsigned NUM_CH = 16;
  localparam int unsigned ADDR_W = 10;
  localparam logic [ADDR_W-1:0] BASE = 10'h300;

  logic clk = 0, rst_ni = 0;
  logic io = 0, wr = 0, rd = 0, simul = 0, bip = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [NUM_CH*16-1:0] codes;

  int vectors = 0, miscompares = 0;
  logic [7:0]  m_lo [NUM_CH];
  logic [7:0]  m_hi [NUM_CH];
  logic [15:0] m_out[NUM_CH];

  always #(CLK_P/2) clk = ~clk;

  dac_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .base_sw_i(BASE[ADDR_W-1:5]),
    .io_cycle_i(io), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .simul_mode_i(simul),
    .bip_zero_i(bip), .dac_code_o(codes)
  );

  function automatic bit in_range(input logic [ADDR_W-1:0] a, input logic c);
    return c && (a[ADDR_W-1:5] == BASE[ADDR_W-1:5]);
  endfunction

  task automatic model_write(input logic [ADDR_W-1:0] a, input logic c, input logic [7:0] d);
    int ch;
    if (!in_range(a, c)) return;
    ch = int'(a[4:1]);
    if (!a[0]) m_lo[ch] = d;
    else begin
      m_hi[ch] = d;
      if (!simul) m_out[ch] = {d, m_lo[ch]};
    end
  endtask

  task automatic model_xfer();
    for (int i = 0; i < NUM_CH; i++) m_out[i] = {m_hi[i], m_lo[i]};
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NUM_CH; i++) begin
      vectors++;
      if (codes[i*16 +: 16] !== m_out[i]) begin
        miscompares++;
        $display("FAIL %s ch%0d got %h exp %h", tag, i, codes[i*16 +: 16], m_out[i]);
      end
    end
  endtask

  task automatic check_rdata();
    vectors++;
    if (rdata !== 8'h00) begin
      miscompares++;
      $display("FAIL R10 rdata got %h exp 00", rdata);
    end
  endtask

  task automatic do_reset(input logic b);
    logic [15:0] z;
    @(negedge clk);
    bip = b; rst_ni = 0;
    z = b ? 16'h8000 : 16'h0000;
    for (int i = 0; i < NUM_CH; i++) begin
      m_lo[i] = z[7:0]; m_hi[i] = z[15:8]; m_out[i] = z;
    end
    @(negedge clk);
    check_all("R1");
    rst_ni = 1;
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic c, input logic [7:0] d);
    @(negedge clk);
    addr = a; io = c; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; io = 0;
    model_write(a, c, d);
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic c);
    @(negedge clk);
    addr = a; io = c; rd = 1;
    @(negedge clk);
    check_rdata();
    rd = 0; io = 0;
    if (in_range(a, c) && simul) model_xfer();
  endtask

  initial begin
    #(CLK_P * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    check_rdata();

    // individual mode sweep
    for (int ch = 0; ch < NUM_CH; ch++) begin
      bus_write(BASE + 10'(2*ch), 1'b1, 8'((ch*17 + 3) & 8'hff));
      check_all("R2");
      bus_write(BASE + 10'(2*ch + 1), 1'b1, 8'((ch*29 + 8'h81) & 8'hff));
      check_all("R3");
    end
    // individual mode: read does nothing
    bus_read(BASE + 10'd4, 1'b1);
    check_all("R3");

    // decode: wrong block, non-I/O cycle
    bus_write(BASE + 10'h20, 1'b1, 8'hAA);
    check_all("R6");
    bus_write(BASE + 10'h21, 1'b1, 8'hAA);
    check_all("R6");
    bus_write(BASE + 10'd1, 1'b0, 8'hAA);
    check_all("R6");
    bus_write(BASE + 10'd0, 1'b0, 8'h55);
    bus_write(BASE + 10'd1, 1'b1, 8'hC3);
    check_all("R6");

    // straps change without bus traffic
    @(negedge clk); simul = 1;
    @(negedge clk); check_all("R9");
    @(negedge clk); bip = 1;
    @(negedge clk); check_all("R9");
    @(negedge clk); bip = 0;
    @(negedge clk); check_all("R9");

    // simultaneous mode sweep
    for (int ch = 0; ch < NUM_CH; ch++) begin
      bus_write(BASE + 10'(2*ch), 1'b1, 8'((ch*13 + 7) & 8'hff));
      bus_write(BASE + 10'(2*ch + 1), 1'b1, 8'((8'hF0 - ch*11) & 8'hff));
      check_all("R4");
    end
    bus_read(BASE - 10'd1, 1'b1);
    check_all("R6");
    bus_read(BASE + 10'd7, 1'b0);
    check_all("R6");
    bus_read(BASE + 10'd7, 1'b1);
    check_all("R5");
    bus_read(BASE + 10'h1F, 1'b1);
    check_all("R5");

    // held read strobe
    bus_write(BASE + 10'd4, 1'b1, 8'h11);
    @(negedge clk);
    addr = BASE; io = 1; rd = 1;
    @(negedge clk);
    model_xfer();
    check_all("R5");
    addr = BASE + 10'd5; wdata = 8'h99; wr = 1;
    @(negedge clk);
    wr = 0;
    model_write(BASE + 10'd5, 1'b1, 8'h99);
    @(negedge clk);
    check_all("R7");
    rd = 0; io = 0;
    @(negedge clk);
    check_all("R7");
    bus_read(BASE + 10'd2, 1'b1);
    check_all("R7");

    // write and read first seen in the same cycle
    @(negedge clk);
    addr = BASE + 10'd11; io = 1; wdata = 8'h3C; wr = 1; rd = 1;
    @(negedge clk);
    model_write(BASE + 10'd11, 1'b1, 8'h3C);
    check_all("R8");
    @(negedge clk);
    model_xfer();
    check_all("R8");
    wr = 0; rd = 0; io = 0;
    @(negedge clk);
    check_all("R8");

    // bipolar reset and low register reset value
    do_reset(1'b1);
    @(negedge clk); simul = 0;
    bus_write(BASE + 10'd1, 1'b1, 8'h12);
    check_all("R1");
    @(negedge clk); simul = 1;
    bus_read(BASE, 1'b1);
    check_all("R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule